// File: doc/BRIEF.md
# I2C Target with Clock Stretching

This block is the target (slave) side of an I2C bus. It follows the bus lines through a two-flop synchronizer and finds START and STOP conditions. After each START it collects a 7-bit address and a read/write bit, then compares the address with a programmable own address. A matching address is acknowledged. After that the target either takes bytes from the controller or sends bytes to it. A read bit of 1 moves it from receiver mode into transmitter mode. Transmitter mode is reached only through the address phase of receiver mode.

On the local side there is a one-byte receive holding register, with a full flag and a read strobe, and a one-byte transmit holding register, with a loaded flag and a write strobe. The target never makes clock pulses. It stretches the controller's clock by pulling SCL low in two cases: a byte has arrived while the receive register is still unread, or a byte is due while no transmit byte is loaded. Both lines are driven only as open-drain pull-low enables.

Top module: `i2c_target_stretch`

## Requirements
- R1: After reset, scl_pull, sda_pull, rx_full, tx_loaded and tx_mode are all 0.
- R2: When the first byte after a START has bits [7:1] equal to own_addr, the target pulls SDA low during the ninth (acknowledge) clock.
- R3: When the address bits do not match, the target gives no acknowledge. It then ignores every byte until the next START: it never pulls SDA or SCL, and rx_full stays 0.
- R4: In receiver mode each byte (MSB first, sampled on SCL rising edges) appears on rx_data with rx_full set, and it is acknowledged. A one-cycle rx_rd clears rx_full on the next cycle.
- R5: If rx_full is still 1 when a further byte completes, the target holds SCL low and keeps rx_data unchanged until rx_rd is given. It then delivers and acknowledges the new byte.
- R6: A matching address with R/W = 1 sets tx_mode to 1. The target then shifts the loaded transmit byte out MSB first, and consuming the byte clears tx_loaded.
- R7: In transmitter mode, if no byte is loaded when the next byte must start, the target holds SCL low until tx_wr is given. It then sends the newly written byte.
- R8: A NACK from the controller after a transmitted byte ends the transfer. SDA is released, tx_mode returns to 0, and later clocks draw no data and do not consume a loaded byte until the next START.
- R9: A repeated START returns the target to address reception in receiver mode (tx_mode = 0). A STOP returns it to idle, where bytes sent without a START are not acknowledged.
- R10: The target only extends a low phase of SCL and never starts one. It changes sda_pull only while the SCL line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sensed SCL bus line |
| sda_in | input | 1 | Sensed SDA bus line |
| scl_pull | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull | output | 1 | 1 pulls SDA low (acknowledge or data 0) |
| own_addr | input | 7 | Own 7-bit target address |
| rx_data | output | 8 | Last received byte |
| rx_full | output | 1 | Receive register holds an unread byte |
| rx_rd | input | 1 | Read strobe, clears rx_full |
| tx_data | input | 8 | Byte to transmit |
| tx_wr | input | 1 | Write strobe, loads tx_data |
| tx_loaded | output | 1 | Transmit register holds a byte not yet sent |
| tx_mode | output | 1 | 1 while in transmitter mode |

## Verification
The bench sends an unread second byte. A target that does not stretch would overwrite rx_data or acknowledge too early, and the measured SCL stall would be zero. It starts a read with nothing loaded after the first byte, so a missing stretch would send stale or all-ones data instead of the late-written byte. Data whose pattern equals the own address, sent after a mismatched address or after a STOP, catches a target that does not stay deaf until START. Clocks after a controller NACK catch a target that keeps driving SDA or eats the next loaded byte. A repeated START inside a read catches a target stuck in transmitter mode.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_RXB,
        ST_RXHOLD,
        ST_RXACK,
        ST_TXLOAD,
        ST_TXB,
        ST_TXACK,
        ST_IGNORE
    } tgt_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [ADDR_W-1:0] own);
        return b[BYTE_W-1:1] == own;
    endfunction

    function automatic logic is_tx_state(input tgt_state_e s);
        return (s == ST_TXLOAD) || (s == ST_TXB) || (s == ST_TXACK);
    endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[g] <= '1;
                    else     pipe[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[g] <= '1;
                    else     pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond
    import i2c_tgt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);
    logic scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        ev.rise  = scl_s & ~scl_d;
        ev.fall  = ~scl_s & scl_d;
        ev.start = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop  = scl_s & scl_d & ~sda_d & sda_s;
        ev.sda   = sda_s;
    end
endmodule

// File: rtl/i2c_tgt_bufs.sv
module i2c_tgt_bufs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rx_load,
    input  logic [W-1:0] rx_byte,
    input  logic         rx_rd,
    output logic [W-1:0] rx_data,
    output logic         rx_full,
    input  logic         tx_wr,
    input  logic [W-1:0] tx_data,
    input  logic         tx_take,
    output logic [W-1:0] tx_byte,
    output logic         tx_loaded
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data <= '0;
            rx_full <= 1'b0;
        end else if (rx_load) begin
            rx_data <= rx_byte;
            rx_full <= 1'b1;
        end else if (rx_rd) begin
            rx_full <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_byte   <= '0;
            tx_loaded <= 1'b0;
        end else begin
            if (tx_take) tx_loaded <= 1'b0;
            if (tx_wr) begin
                tx_byte   <= tx_data;
                tx_loaded <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter int W         = BYTE_W,
    parameter int HOLD_TAIL = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              rx_full,
    input  logic              tx_loaded,
    input  logic [W-1:0]      tx_byte,
    output logic              rx_load,
    output logic [W-1:0]      rx_byte,
    output logic              tx_take,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic              tx_mode
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] FULL = CW'(W);

    tgt_state_e           state;
    logic [W-1:0]         sh;
    logic [CW-1:0]        cnt;
    logic                 rw_q;
    logic                 ack_ok;
    logic                 hold_now;
    logic [HOLD_TAIL-1:0] tail;

    // Stretch request and its release tail: SCL stays low a little
    // after the request drops so SDA settles before SCL rises.
    assign hold_now = ((state == ST_RXHOLD) && rx_full) ||
                      ((state == ST_TXLOAD) && !tx_loaded);

    always_ff @(posedge clk) begin
        if (rst) tail <= '0;
        else     tail <= {tail[HOLD_TAIL-2:0], hold_now};
    end

    assign scl_pull = hold_now | (|tail);
    assign rx_load  = (state == ST_RXHOLD) && !rx_full;
    assign rx_byte  = sh;
    assign tx_take  = (state == ST_TXLOAD) && tx_loaded;
    assign tx_mode  = is_tx_state(state);

    always_comb begin
        case (state)
            ST_AACK:  sda_pull = 1'b1;
            ST_RXACK: sda_pull = 1'b1;
            ST_TXB:   sda_pull = ~sh[W-1];
            default:  sda_pull = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            sh     <= '0;
            cnt    <= '0;
            rw_q   <= 1'b0;
            ack_ok <= 1'b0;
        end else if (ev.start) begin
            state <= ST_ADDR;
            cnt   <= '0;
        end else if (ev.stop) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (ev.rise && cnt != FULL) begin
                        sh  <= {sh[W-2:0], ev.sda};
                        cnt <= cnt + 1'b1;
                    end else if (ev.fall && cnt == FULL) begin
                        rw_q  <= sh[0];
                        state <= addr_hit(sh, own_addr) ? ST_AACK : ST_IGNORE;
                    end
                end
                ST_AACK: begin
                    if (ev.fall) begin
                        cnt   <= '0;
                        state <= rw_q ? ST_TXLOAD : ST_RXB;
                    end
                end
                ST_RXB: begin
                    if (ev.rise && cnt != FULL) begin
                        sh  <= {sh[W-2:0], ev.sda};
                        cnt <= cnt + 1'b1;
                    end else if (ev.fall && cnt == FULL) begin
                        state <= ST_RXHOLD;
                    end
                end
                ST_RXHOLD: begin
                    if (!rx_full) state <= ST_RXACK;
                end
                ST_RXACK: begin
                    if (ev.fall) begin
                        cnt   <= '0;
                        state <= ST_RXB;
                    end
                end
                ST_TXLOAD: begin
                    if (tx_loaded) begin
                        sh    <= tx_byte;
                        cnt   <= '0;
                        state <= ST_TXB;
                    end
                end
                ST_TXB: begin
                    if (ev.rise && cnt != FULL) begin
                        cnt <= cnt + 1'b1;
                    end else if (ev.fall) begin
                        if (cnt == FULL) state <= ST_TXACK;
                        else             sh    <= {sh[W-2:0], 1'b1};
                    end
                end
                ST_TXACK: begin
                    if (ev.rise) begin
                        ack_ok <= ~ev.sda;
                    end else if (ev.fall) begin
                        state <= ack_ok ? ST_TXLOAD : ST_IGNORE;
                    end
                end
                ST_IGNORE: ;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_target_stretch.sv
module i2c_target_stretch
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull,
    input  logic [ADDR_W-1:0] own_addr,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_full,
    input  logic              rx_rd,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_wr,
    output logic              tx_loaded,
    output logic              tx_mode
);
    logic [1:0]        lines_s;
    bus_ev_t           ev;
    logic              rx_load, tx_take;
    logic [BYTE_W-1:0] rx_byte, tx_byte;

    i2c_tgt_sync #(.STAGES(2), .W(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_in, sda_in}),
        .q   (lines_s)
    );

    i2c_tgt_cond u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_s (lines_s[1]),
        .sda_s (lines_s[0]),
        .ev    (ev)
    );

    i2c_tgt_engine #(.W(BYTE_W), .HOLD_TAIL(2)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .own_addr  (own_addr),
        .rx_full   (rx_full),
        .tx_loaded (tx_loaded),
        .tx_byte   (tx_byte),
        .rx_load   (rx_load),
        .rx_byte   (rx_byte),
        .tx_take   (tx_take),
        .scl_pull  (scl_pull),
        .sda_pull  (sda_pull),
        .tx_mode   (tx_mode)
    );

    i2c_tgt_bufs #(.W(BYTE_W)) u_bufs (
        .clk       (clk),
        .rst       (rst),
        .rx_load   (rx_load),
        .rx_byte   (rx_byte),
        .rx_rd     (rx_rd),
        .rx_data   (rx_data),
        .rx_full   (rx_full),
        .tx_wr     (tx_wr),
        .tx_data   (tx_data),
        .tx_take   (tx_take),
        .tx_byte   (tx_byte),
        .tx_loaded (tx_loaded)
    );
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
    input logic       clk,
    input logic       rst,
    input logic       scl_in,
    input logic       scl_pull,
    input logic       sda_pull,
    input logic [7:0] rx_data,
    input logic       rx_full,
    input logic       rx_rd
);
    // R10
    sda_in_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull) |-> !scl_in);

    // R10
    no_clock_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_pull) |-> !$past(scl_in));

    // R4
    rx_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_rd && rx_full) |=> !rx_full);

    // R5
    rx_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_full && !rx_rd) |=> (rx_full && $stable(rx_data)));
endmodule

bind i2c_target_stretch i2c_tgt_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_in),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull),
    .rx_data  (rx_data),
    .rx_full  (rx_full),
    .rx_rd    (rx_rd)
);

// File: tb/i2c_target_stretch_bench.sv
`timescale 1ns/1ps
module i2c_target_stretch_bench;
    localparam int H = 20;
    localparam logic [6:0] OWN = 7'h5A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_line, sda_line;
    logic scl_pull, sda_pull;
    logic [7:0] rx_data;
    logic rx_full, tx_loaded, tx_mode;
    logic rx_rd = 1'b0, tx_wr = 1'b0;
    logic [7:0] tx_data = 8'h00;

    int checks = 0, errors = 0;
    int sda_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign scl_line = scl_m & ~scl_pull;
    assign sda_line = sda_m & ~sda_pull;

    i2c_target_stretch u_i2c_target_stretch (
        .clk(clk), .rst(rst), .scl_in(scl_line), .sda_in(sda_line),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .own_addr(OWN),
        .rx_data(rx_data), .rx_full(rx_full), .rx_rd(rx_rd),
        .tx_data(tx_data), .tx_wr(tx_wr), .tx_loaded(tx_loaded),
        .tx_mode(tx_mode)
    );

    always @(posedge clk) if (sda_pull) sda_cnt <= sda_cnt + 1;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_clk(input logic b, output logic seen, output int stall);
        sda_m = b;
        wait_cyc(H);
        scl_m = 1'b1;
        stall = 0;
        @(negedge clk);
        while (!scl_line && stall < 5000) begin
            stall++;
            @(negedge clk);
        end
        wait_cyc(H / 2);
        seen = sda_line;
        wait_cyc(H / 2);
        scl_m = 1'b0;
        wait_cyc(H);
    endtask

    task automatic m_start();
        sda_m = 1'b1; wait_cyc(H);
        scl_m = 1'b1; wait_cyc(H);
        sda_m = 1'b0; wait_cyc(H);
        scl_m = 1'b0; wait_cyc(H);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wait_cyc(H);
        scl_m = 1'b1; wait_cyc(H);
        sda_m = 1'b1; wait_cyc(H);
    endtask

    task automatic write_byte(input logic [7:0] v, output logic acked, output int smax);
        logic s;
        int st;
        smax = 0;
        for (int i = 7; i >= 0; i--) begin
            bit_clk(v[i], s, st);
            if (st > smax) smax = st;
        end
        bit_clk(1'b1, s, st);
        if (st > smax) smax = st;
        acked = ~s;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] v, output int smax);
        logic s;
        int st;
        smax = 0;
        for (int i = 7; i >= 0; i--) begin
            bit_clk(1'b1, s, st);
            v[i] = s;
            if (st > smax) smax = st;
        end
        bit_clk(~give_ack, s, st);
    endtask

    task automatic pulse_rd();
        rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_wr(input logic [7:0] v);
        tx_data = v; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0; @(negedge clk);
    endtask

    // {address, data byte, expect match}
    localparam logic [15:0] VEC [6] = '{
        {7'h5A, 8'hA5, 1'b1},
        {7'h5B, 8'h3C, 1'b0},
        {7'h5A, 8'h00, 1'b1},
        {7'h2D, 8'hB4, 1'b0},
        {7'h5A, 8'hFF, 1'b1},
        {7'h1A, 8'h81, 1'b0}
    };

    initial begin
        logic ack;
        logic [7:0] v;
        int st, st2;
        logic s;

        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);
        // R1
        chk({scl_pull, sda_pull, rx_full, tx_loaded, tx_mode} == 5'b0,
            "R1 reset outputs", {scl_pull, sda_pull, rx_full, tx_loaded, tx_mode}, 0);

        for (int i = 0; i < 6; i++) begin
            logic [6:0] a;
            logic [7:0] d;
            logic e;
            {a, d, e} = VEC[i];
            sda_cnt = 0;
            m_start();
            write_byte({a, 1'b0}, ack, st);
            chk(ack == e, e ? "R2 address ack" : "R3 no address ack", ack, e);
            write_byte(d, ack, st);
            chk(ack == e, e ? "R4 data ack" : "R3 data ignored", ack, e);
            m_stop();
            chk(rx_full == e, e ? "R4 rx_full set" : "R3 rx_full stays 0", rx_full, e);
            if (e) begin
                chk(rx_data == d, "R4 rx_data", rx_data, d);
                pulse_rd();
                chk(rx_full == 1'b0, "R4 rx_rd clears", rx_full, 0);
            end else begin
                chk(sda_cnt == 0, "R3 SDA never pulled", sda_cnt, 0);
            end
        end

        // R5: second byte arrives while first is unread
        m_start();
        write_byte({OWN, 1'b0}, ack, st);
        write_byte(8'h11, ack, st);
        chk(rx_data == 8'h11 && rx_full, "R4 first byte", rx_data, 8'h11);
        fork
            write_byte(8'h22, ack, st);
            begin
                wait_cyc(800);
                chk(scl_pull == 1'b1, "R5 SCL held while full", scl_pull, 1);
                chk(rx_data == 8'h11, "R5 rx_data kept", rx_data, 8'h11);
                pulse_rd();
            end
        join
        chk(st > 200, "R5 stretch length", st, 200);
        chk(ack == 1'b1, "R5 ack after read", ack, 1);
        chk(rx_data == 8'h22 && rx_full, "R5 new byte", rx_data, 8'h22);
        m_stop();
        pulse_rd();

        // R6 / R7 / R8
        pulse_wr(8'hC3);
        chk(tx_loaded == 1'b1, "R6 tx_loaded", tx_loaded, 1);
        m_start();
        write_byte({OWN, 1'b1}, ack, st);
        chk(ack == 1'b1, "R6 read address ack", ack, 1);
        chk(tx_mode == 1'b1, "R6 tx_mode", tx_mode, 1);
        read_byte(1'b1, v, st);
        chk(v == 8'hC3, "R6 sent byte", v, 8'hC3);
        chk(tx_loaded == 1'b0, "R6 byte consumed", tx_loaded, 0);
        fork
            read_byte(1'b0, v, st);
            begin
                wait_cyc(300);
                chk(scl_pull == 1'b1, "R7 SCL held while empty", scl_pull, 1);
                pulse_wr(8'h5E);
            end
        join
        chk(v == 8'h5E, "R7 late byte", v, 8'h5E);
        chk(st > 100, "R7 stretch length", st, 100);
        pulse_wr(8'h77);
        sda_cnt = 0;
        st2 = 0;
        for (int i = 0; i < 9; i++) begin
            bit_clk(1'b1, s, st);
            if (st > st2) st2 = st;
        end
        chk(sda_cnt == 0, "R8 SDA released after NACK", sda_cnt, 0);
        chk(st2 == 0, "R10 no stretch while ignoring", st2, 0);
        chk(tx_loaded == 1'b1, "R8 byte not consumed", tx_loaded, 1);
        chk(tx_mode == 1'b0, "R8 tx_mode off", tx_mode, 0);
        m_stop();

        // R9: repeated START, then STOP
        m_start();
        write_byte({OWN, 1'b1}, ack, st);
        chk(tx_mode == 1'b1, "R9 in tx_mode", tx_mode, 1);
        read_byte(1'b0, v, st);
        chk(v == 8'h77, "R9 sent byte", v, 8'h77);
        m_start();
        chk(tx_mode == 1'b0, "R9 repeated START to receiver", tx_mode, 0);
        write_byte({OWN, 1'b0}, ack, st);
        chk(ack == 1'b1, "R9 address after restart", ack, 1);
        write_byte(8'h42, ack, st);
        chk(rx_data == 8'h42 && rx_full, "R9 data after restart", rx_data, 8'h42);
        m_stop();
        pulse_rd();
        write_byte({OWN, 1'b0}, ack, st);
        chk(ack == 1'b0, "R9 idle after STOP", ack, 0);
        chk(rx_full == 1'b0, "R9 no data when idle", rx_full, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule